// File: doc/BRIEF.md
# Data-Polling NOR Flash Program Sequencer

This block drives the command traffic for a NOR flash that is unlocked with a two-write prefix and that reports progress through data polling. A client selects one of three operations: block erase, single-word program or buffered program. The client pulses `start` with a target address, a data word and (for the buffered case) a word count. The sequencer emits the unlock prefix and the command writes, then polls the device. Polling compares the polarity bits of the read-back word with the last word written, and watches the device's timeout flag and its buffered-abort flag. When polling ends, the sequencer sends the device back to read mode and, if polling succeeded, reads back what it wrote.

The flash bus is a plain word-wide port. A write is the cycle where `flWe` is high. A read is the cycle where `flRe` is high, and `flRdata` is taken in that same cycle. Bus electrical timing and device geometry belong to other blocks. Buffered data is fetched from the client through an index/data pair: `bufRdData` must return the word at `bufRdIdx` within the same cycle.

Top module: `nor_poll_seq`

## Requirements
- R1: Every command sequence begins with two unlock writes: 0xAA at word offset 0x555, then 0x55 at offset 0x2AA. An erase runs this prefix twice.
- R2: A single-word program writes 0xA0 at offset 0x555, then writes the data word at the target address.
- R3: An erase writes prefix, 0x80 at 0x555, prefix, and then 0x30 at the block base. The block base is the target address with its low BLOCK_AW bits cleared. The expected polled value for an erase is all ones.
- R4: A buffered program writes prefix and 0x25 at the block base, then the count minus one at the block base, then the words to target+0 .. target+count-1 in index order, then 0x29 at the block base.
- R5: Polling reads the address of the last word written. An operation completes when bit 7 and bit 15 of the read equal those bits of the expected word.
- R6: If a poll read mismatches and bit 5 is set, exactly one more read is made. If that read matches, the operation proceeds as a success; otherwise the result is device-timeout (1).
- R7: During a buffered program only, a mismatching poll read with bit 1 set triggers one more read. If that read mismatches, the result is abort (2), and the prefix is issued again before the reset write. For other operations, bit 1 is not treated as an abort.
- R8: Every operation that has started ends with the write 0xF0 at offset 0x555 before `done` is raised.
- R9: After a successful poll, the sequencer reads back what was written: the programmed word, every buffered word in index order, or the erased block base against all ones. Any mismatch gives verify-mismatch (3); otherwise the result is pass (0).
- R10: After POLL_LIMIT poll reads without completion (and with no flag-triggered re-read), the result is poll-limit (4). This limit is independent of the device's timeout flag.
- R11: `done` is a one-cycle pulse, and `result` holds its code until the next start. `busy` rises in the cycle after an accepted start. A start is ignored while `busy` is high or when `opKind` is 3. The operation codes are program 0, erase 1 and buffered 2.
- R12: After reset, `busy`, `done`, `flWe` and `flRe` are low. There is no bus access while idle, and a read and a write never share a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| opKind | input | 2 | 0 program, 1 erase, 2 buffered program, 3 none |
| opAddr | input | ADDR_W | Target word address |
| opData | input | DATA_W | Word for single program |
| bufCount | input | $clog2(BUF_WORDS+1) | Buffered word count, 1..BUF_WORDS |
| bufRdIdx | output | IDX_W | Index of buffered word requested |
| bufRdData | input | DATA_W | Buffered word at bufRdIdx, same cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 pass, 1 device timeout, 2 abort, 3 verify mismatch, 4 poll limit |
| flAddr | output | ADDR_W | Flash word address |
| flWdata | output | DATA_W | Flash write data |
| flWe | output | 1 | Flash write cycle |
| flRe | output | 1 | Flash read cycle |
| flRdata | input | DATA_W | Flash read data |

## Verification
The bench builds the block with a 12-bit address, 64-word blocks, an 8-word buffer and a poll limit of 40. These values let a behavioural flash model span several blocks, and let a buffered program fill the buffer completely. They also let the poll-limit exit be reached within a few dozen cycles. The model can inject a persistent timeout flag, a timeout flag that clears one cycle later, an abort flag and a corrupted stored bit. This makes the re-read race, the abort recovery, the flag that is ignored outside buffered mode, and the verify failure all observable at the ports.

// File: rtl/nor_poll_pkg.sv
package nor_poll_pkg;

  localparam logic [7:0] UNLK_VAL1       = 8'hAA;
  localparam logic [7:0] UNLK_VAL2       = 8'h55;
  localparam logic [7:0] CMD_PROGRAM     = 8'hA0;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h80;
  localparam logic [7:0] CMD_ERASE_BLOCK = 8'h30;
  localparam logic [7:0] CMD_BUF_LOAD    = 8'h25;
  localparam logic [7:0] CMD_BUF_CONFIRM = 8'h29;
  localparam logic [7:0] CMD_READ_MODE   = 8'hF0;

  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_ERASE = 2'd1,
    OP_BUF   = 2'd2,
    OP_NONE  = 2'd3
  } opKind_e;

  typedef enum logic [2:0] {
    RES_PASS        = 3'd0,
    RES_DEV_TIMEOUT = 3'd1,
    RES_ABORT       = 3'd2,
    RES_VERIFY      = 3'd3,
    RES_POLL_LIMIT  = 3'd4
  } result_e;

  typedef enum logic [2:0] {
    AS_UNLK1, AS_UNLK2, AS_CMD, AS_BLOCK, AS_TARGET, AS_POLL
  } addrSel_e;

  typedef enum logic [2:0] {
    DS_UNLK1, DS_UNLK2, DS_CMD, DS_COUNT, DS_WORD
  } dataSel_e;

  typedef struct packed {
    logic     wrEn;
    logic     rdEn;
    addrSel_e addrSel;
    dataSel_e dataSel;
    logic [7:0] cmdCode;
    logic     loadOp;
    logic     latchExp;
    logic     idxClr;
    logic     idxInc;
    logic     pollClr;
    logic     pollInc;
  } dpCtrl_t;

  typedef struct packed {
    opKind_e kind;
    logic    pollMatch;
    logic    toFlag;
    logic    abFlag;
    logic    verifyEq;
    logic    idxLast;
    logic    pollExpired;
  } dpStat_t;

endpackage

// File: rtl/nor_poll_dp.sv
module nor_poll_dp
  import nor_poll_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 22,
  parameter int BLOCK_AW   = 15,
  parameter int BUF_WORDS  = 16,
  parameter int POLL_LIMIT = 1000000,
  parameter int UNLK_ADDR1 = 'h555,
  parameter int UNLK_ADDR2 = 'h2AA,
  parameter int CMD_ADDR   = 'h555,
  localparam int CNT_W     = $clog2(BUF_WORDS + 1),
  localparam int IDX_W     = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1,
  localparam int POLL_W    = $clog2(POLL_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [1:0]        opKind,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] opData,
  input  logic [CNT_W-1:0]  bufCount,
  output logic [IDX_W-1:0]  bufRdIdx,
  input  logic [DATA_W-1:0] bufRdData,
  output logic [ADDR_W-1:0] flAddr,
  output logic [DATA_W-1:0] flWdata,
  input  logic [DATA_W-1:0] flRdata,
  output dpStat_t           stat
);

  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  opKind_e           kindQ;
  logic [ADDR_W-1:0] targetQ;
  logic [DATA_W-1:0] dataQ;
  logic [CNT_W-1:0]  countQ;
  logic [IDX_W-1:0]  idxQ;
  logic [POLL_W-1:0] pollQ;
  logic [DATA_W-1:0] expQ;
  logic [ADDR_W-1:0] pollAddrQ;

  logic [ADDR_W-1:0] blockBase;
  logic [DATA_W-1:0] wordOut;
  logic [DATA_W-1:0] verifyWord;
  logic              hiOk;

  assign blockBase = {targetQ[ADDR_W-1:BLOCK_AW], {BLOCK_AW{1'b0}}};
  assign wordOut   = (kindQ == OP_BUF) ? bufRdData : dataQ;
  assign bufRdIdx  = idxQ;

  always_comb begin
    unique case (ctl.addrSel)
      AS_UNLK1:  flAddr = ADDR_W'(UNLK_ADDR1);
      AS_UNLK2:  flAddr = ADDR_W'(UNLK_ADDR2);
      AS_CMD:    flAddr = ADDR_W'(CMD_ADDR);
      AS_BLOCK:  flAddr = blockBase;
      AS_TARGET: flAddr = targetQ + ADDR_W'(idxQ);
      default:   flAddr = pollAddrQ;
    endcase
  end

  always_comb begin
    unique case (ctl.dataSel)
      DS_UNLK1: flWdata = DATA_W'(UNLK_VAL1);
      DS_UNLK2: flWdata = DATA_W'(UNLK_VAL2);
      DS_CMD:   flWdata = DATA_W'(ctl.cmdCode);
      DS_COUNT: flWdata = DATA_W'(countQ - CNT_W'(1));
      default:  flWdata = wordOut;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindQ     <= OP_NONE;
      targetQ   <= '0;
      dataQ     <= '0;
      countQ    <= CNT_W'(1);
      idxQ      <= '0;
      pollQ     <= '0;
      expQ      <= '0;
      pollAddrQ <= '0;
    end else begin
      if (ctl.loadOp) begin
        kindQ   <= opKind_e'(opKind);
        targetQ <= opAddr;
        dataQ   <= opData;
        countQ  <= (opKind == OP_BUF) ? bufCount : CNT_W'(1);
      end
      if (ctl.loadOp || ctl.idxClr) idxQ <= '0;
      else if (ctl.idxInc)          idxQ <= idxQ + IDX_W'(1);
      if (ctl.pollClr)              pollQ <= '0;
      else if (ctl.pollInc)         pollQ <= pollQ + POLL_W'(1);
      if (ctl.latchExp) begin
        pollAddrQ <= flAddr;
        expQ      <= (kindQ == OP_ERASE) ? ALL_ONES : flWdata;
      end
    end
  end

  generate
    if (DATA_W >= 16) begin : g_wideBus
      assign hiOk = (flRdata[15] == expQ[15]);
    end else begin : g_narrowBus
      assign hiOk = 1'b1;
    end
  endgenerate

  always_comb begin
    unique case (kindQ)
      OP_ERASE: verifyWord = ALL_ONES;
      OP_BUF:   verifyWord = bufRdData;
      default:  verifyWord = dataQ;
    endcase
  end

  assign stat.kind        = kindQ;
  assign stat.pollMatch   = (flRdata[7] == expQ[7]) && hiOk;
  assign stat.toFlag      = flRdata[5];
  assign stat.abFlag      = flRdata[1];
  assign stat.verifyEq    = (flRdata == verifyWord);
  assign stat.idxLast     = ((CNT_W'(idxQ) + CNT_W'(1)) == countQ);
  assign stat.pollExpired = (pollQ == POLL_W'(POLL_LIMIT - 1));

endmodule

// File: rtl/nor_poll_ctrl.sv
module nor_poll_ctrl
  import nor_poll_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] opKind,
  input  dpStat_t    stat,
  output dpCtrl_t    ctl,
  output logic       busy,
  output logic       done,
  output logic [2:0] result
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_UL1, ST_UL2, ST_CMD, ST_ERASE, ST_BLOAD, ST_BCNT,
    ST_DATA, ST_BCONF, ST_POLL, ST_REREAD, ST_RESET, ST_VERIFY, ST_DONE
  } state_e;

  state_e  stQ, stD;
  logic    phaseQ, phaseD;
  logic    recoverQ, recoverD;
  result_e resQ, resD;
  result_e pendQ, pendD;

  always_comb begin
    ctl      = '0;
    stD      = stQ;
    phaseD   = phaseQ;
    recoverD = recoverQ;
    resD     = resQ;
    pendD    = pendQ;
    unique case (stQ)
      ST_IDLE: begin
        if (start && (opKind != OP_NONE)) begin
          ctl.loadOp = 1'b1;
          phaseD     = 1'b0;
          recoverD   = 1'b0;
          resD       = RES_PASS;
          stD        = ST_UL1;
        end
      end
      ST_UL1: begin
        ctl.wrEn    = 1'b1;
        ctl.addrSel = AS_UNLK1;
        ctl.dataSel = DS_UNLK1;
        stD         = ST_UL2;
      end
      ST_UL2: begin
        ctl.wrEn    = 1'b1;
        ctl.addrSel = AS_UNLK2;
        ctl.dataSel = DS_UNLK2;
        if (recoverQ) begin
          recoverD = 1'b0;
          stD      = ST_RESET;
        end else begin
          unique case (stat.kind)
            OP_ERASE: stD = phaseQ ? ST_ERASE : ST_CMD;
            OP_BUF:   stD = ST_BLOAD;
            default:  stD = ST_CMD;
          endcase
        end
      end
      ST_CMD: begin
        ctl.wrEn    = 1'b1;
        ctl.addrSel = AS_CMD;
        ctl.dataSel = DS_CMD;
        if (stat.kind == OP_ERASE) begin
          ctl.cmdCode = CMD_ERASE_SETUP;
          phaseD      = 1'b1;
          stD         = ST_UL1;
        end else begin
          ctl.cmdCode = CMD_PROGRAM;
          stD         = ST_DATA;
        end
      end
      ST_ERASE: begin
        ctl.wrEn     = 1'b1;
        ctl.addrSel  = AS_BLOCK;
        ctl.dataSel  = DS_CMD;
        ctl.cmdCode  = CMD_ERASE_BLOCK;
        ctl.latchExp = 1'b1;
        ctl.pollClr  = 1'b1;
        stD          = ST_POLL;
      end
      ST_BLOAD: begin
        ctl.wrEn    = 1'b1;
        ctl.addrSel = AS_BLOCK;
        ctl.dataSel = DS_CMD;
        ctl.cmdCode = CMD_BUF_LOAD;
        stD         = ST_BCNT;
      end
      ST_BCNT: begin
        ctl.wrEn    = 1'b1;
        ctl.addrSel = AS_BLOCK;
        ctl.dataSel = DS_COUNT;
        stD         = ST_DATA;
      end
      ST_DATA: begin
        ctl.wrEn     = 1'b1;
        ctl.addrSel  = AS_TARGET;
        ctl.dataSel  = DS_WORD;
        ctl.latchExp = 1'b1;
        if (!stat.idxLast) begin
          ctl.idxInc = 1'b1;
        end else if (stat.kind == OP_BUF) begin
          stD = ST_BCONF;
        end else begin
          ctl.idxClr  = 1'b1;
          ctl.pollClr = 1'b1;
          stD         = ST_POLL;
        end
      end
      ST_BCONF: begin
        ctl.wrEn    = 1'b1;
        ctl.addrSel = AS_BLOCK;
        ctl.dataSel = DS_CMD;
        ctl.cmdCode = CMD_BUF_CONFIRM;
        ctl.idxClr  = 1'b1;
        ctl.pollClr = 1'b1;
        stD         = ST_POLL;
      end
      ST_POLL: begin
        ctl.rdEn    = 1'b1;
        ctl.addrSel = AS_POLL;
        ctl.pollInc = 1'b1;
        if (stat.pollMatch) begin
          resD = RES_PASS;
          stD  = ST_RESET;
        end else if (stat.toFlag) begin
          pendD = RES_DEV_TIMEOUT;
          stD   = ST_REREAD;
        end else if (stat.abFlag && (stat.kind == OP_BUF)) begin
          pendD = RES_ABORT;
          stD   = ST_REREAD;
        end else if (stat.pollExpired) begin
          resD = RES_POLL_LIMIT;
          stD  = ST_RESET;
        end
      end
      ST_REREAD: begin
        ctl.rdEn    = 1'b1;
        ctl.addrSel = AS_POLL;
        if (stat.pollMatch) begin
          resD = RES_PASS;
          stD  = ST_RESET;
        end else begin
          resD = pendQ;
          if (pendQ == RES_ABORT) begin
            recoverD = 1'b1;
            stD      = ST_UL1;
          end else begin
            stD = ST_RESET;
          end
        end
      end
      ST_RESET: begin
        ctl.wrEn    = 1'b1;
        ctl.addrSel = AS_CMD;
        ctl.dataSel = DS_CMD;
        ctl.cmdCode = CMD_READ_MODE;
        stD         = (resQ == RES_PASS) ? ST_VERIFY : ST_DONE;
      end
      ST_VERIFY: begin
        ctl.rdEn    = 1'b1;
        ctl.addrSel = (stat.kind == OP_ERASE) ? AS_BLOCK : AS_TARGET;
        if (!stat.verifyEq) begin
          resD = RES_VERIFY;
          stD  = ST_DONE;
        end else if (stat.idxLast) begin
          stD = ST_DONE;
        end else begin
          ctl.idxInc = 1'b1;
        end
      end
      default: begin
        stD = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ      <= ST_IDLE;
      phaseQ   <= 1'b0;
      recoverQ <= 1'b0;
      resQ     <= RES_PASS;
      pendQ    <= RES_DEV_TIMEOUT;
    end else begin
      stQ      <= stD;
      phaseQ   <= phaseD;
      recoverQ <= recoverD;
      resQ     <= resD;
      pendQ    <= pendD;
    end
  end

  assign busy   = (stQ != ST_IDLE);
  assign done   = (stQ == ST_DONE);
  assign result = resQ;

endmodule

// File: rtl/nor_poll_seq.sv
module nor_poll_seq
  import nor_poll_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 22,
  parameter int BLOCK_AW   = 15,
  parameter int BUF_WORDS  = 16,
  parameter int POLL_LIMIT = 1000000,
  parameter int UNLK_ADDR1 = 'h555,
  parameter int UNLK_ADDR2 = 'h2AA,
  parameter int CMD_ADDR   = 'h555,
  localparam int CNT_W     = $clog2(BUF_WORDS + 1),
  localparam int IDX_W     = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        opKind,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] opData,
  input  logic [CNT_W-1:0]  bufCount,
  output logic [IDX_W-1:0]  bufRdIdx,
  input  logic [DATA_W-1:0] bufRdData,
  output logic              busy,
  output logic              done,
  output logic [2:0]        result,
  output logic [ADDR_W-1:0] flAddr,
  output logic [DATA_W-1:0] flWdata,
  output logic              flWe,
  output logic              flRe,
  input  logic [DATA_W-1:0] flRdata
);

  dpCtrl_t ctl;
  dpStat_t stat;

  nor_poll_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .opKind (opKind),
    .stat   (stat),
    .ctl    (ctl),
    .busy   (busy),
    .done   (done),
    .result (result)
  );

  nor_poll_dp #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .BLOCK_AW   (BLOCK_AW),
    .BUF_WORDS  (BUF_WORDS),
    .POLL_LIMIT (POLL_LIMIT),
    .UNLK_ADDR1 (UNLK_ADDR1),
    .UNLK_ADDR2 (UNLK_ADDR2),
    .CMD_ADDR   (CMD_ADDR)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .opKind    (opKind),
    .opAddr    (opAddr),
    .opData    (opData),
    .bufCount  (bufCount),
    .bufRdIdx  (bufRdIdx),
    .bufRdData (bufRdData),
    .flAddr    (flAddr),
    .flWdata   (flWdata),
    .flRdata   (flRdata),
    .stat      (stat)
  );

  assign flWe = ctl.wrEn;
  assign flRe = ctl.rdEn;

endmodule

// File: rtl/nor_poll_chk.sv
module nor_poll_chk #(
  parameter int DATA_W     = 16,
  parameter int POLL_LIMIT = 1000000,
  parameter int BUF_WORDS  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [1:0]        opKind,
  input logic              busy,
  input logic              done,
  input logic [2:0]        result,
  input logic              flWe,
  input logic              flRe,
  input logic [DATA_W-1:0] flWdata
);

  localparam int RUN_MAX = POLL_LIMIT + BUF_WORDS;

  logic [31:0] rdRun;
  logic        rstSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdRun   <= '0;
      rstSeen <= 1'b0;
    end else begin
      rdRun <= flRe ? rdRun + 32'd1 : 32'd0;
      if (!busy) rstSeen <= 1'b0;
      else if (flWe && (flWdata[7:0] == 8'hF0)) rstSeen <= 1'b1;
    end
  end

  p_no_rd_wr_overlap_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(flWe && flRe));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!flWe && !flRe));

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_start_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && (opKind != 2'd3)) |=> busy);

  p_result_code_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (result <= 3'd4));

  p_reset_before_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> rstSeen);

  p_poll_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    flRe |-> (rdRun < 32'(RUN_MAX)));

endmodule

bind nor_poll_seq nor_poll_chk #(
  .DATA_W     (DATA_W),
  .POLL_LIMIT (POLL_LIMIT),
  .BUF_WORDS  (BUF_WORDS)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .opKind  (opKind),
  .busy    (busy),
  .done    (done),
  .result  (result),
  .flWe    (flWe),
  .flRe    (flRe),
  .flWdata (flWdata)
);

// File: tb/tb_nor_poll_seq.sv
module tb_nor_poll_seq;

  localparam int CLK_P      = 10;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 12;
  localparam int BLOCK_AW   = 6;
  localparam int BUF_WORDS  = 8;
  localparam int POLL_LIMIT = 40;
  localparam int CNT_W      = $clog2(BUF_WORDS + 1);
  localparam int IDX_W      = $clog2(BUF_WORDS);
  localparam int MEM_N      = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [1:0]        opKind = 2'd0;
  logic [ADDR_W-1:0] opAddr = '0;
  logic [DATA_W-1:0] opData = '0;
  logic [CNT_W-1:0]  bufCount = CNT_W'(1);
  logic [IDX_W-1:0]  bufRdIdx;
  logic [DATA_W-1:0] bufRdData;
  logic              busy, done;
  logic [2:0]        result;
  logic [ADDR_W-1:0] flAddr;
  logic [DATA_W-1:0] flWdata;
  logic              flWe, flRe;
  logic [DATA_W-1:0] flRdata;

  always #(CLK_P/2) clk = ~clk;

  nor_poll_seq #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BLOCK_AW(BLOCK_AW),
    .BUF_WORDS(BUF_WORDS), .POLL_LIMIT(POLL_LIMIT)
  ) dut (
    .clk(clk), .rstN(rstN), .start(start), .opKind(opKind), .opAddr(opAddr),
    .opData(opData), .bufCount(bufCount), .bufRdIdx(bufRdIdx),
    .bufRdData(bufRdData), .busy(busy), .done(done), .result(result),
    .flAddr(flAddr), .flWdata(flWdata), .flWe(flWe), .flRe(flRe),
    .flRdata(flRdata)
  );

  // client buffer
  logic [DATA_W-1:0] bufMem [0:BUF_WORDS-1];
  assign bufRdData = bufMem[bufRdIdx];

  // behavioural flash model
  logic [DATA_W-1:0] mem [0:MEM_N-1];
  int   busyLen = 4;
  int   faultKind = 0; // 0 none, 1 timeout, 2 abort flag, 3 short timeout, 4 corrupt
  logic [1:0]  ulSt = 2'd0;
  logic        progArmed = 1'b0, eraseArmed = 1'b0;
  logic [1:0]  bufSt = 2'd0;
  int          bufLeft = 0;
  logic        mBusy = 1'b0, stTo = 1'b0, stAb = 1'b0, raceHold = 1'b0;
  int          busyCnt = 0;
  logic [DATA_W-1:0] lastData = '0;
  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] corruptMask;

  assign corruptMask = (faultKind == 4) ? DATA_W'(1) : '0;
  always_comb begin
    statusWord = '0;
    statusWord[15] = ~lastData[15];
    statusWord[7]  = ~lastData[7];
    statusWord[5]  = stTo;
    statusWord[1]  = stAb;
  end
  assign flRdata = (mBusy || stTo || stAb) ? statusWord : mem[flAddr];

  // write log
  logic [ADDR_W-1:0] logA [$];
  logic [DATA_W-1:0] logD [$];
  logic [ADDR_W-1:0] expA [$];
  logic [DATA_W-1:0] expD [$];

  always @(posedge clk) begin
    if (raceHold) begin
      stTo     <= 1'b0;
      raceHold <= 1'b0;
    end
    if (mBusy) begin
      if (busyCnt == 0) begin
        mBusy <= 1'b0;
        case (faultKind)
          1: stTo <= 1'b1;
          2: stAb <= 1'b1;
          3: begin stTo <= 1'b1; raceHold <= 1'b1; end
          default: ;
        endcase
      end else busyCnt <= busyCnt - 1;
    end
    if (flWe) begin
      logA.push_back(flAddr);
      logD.push_back(flWdata);
      if (progArmed) begin
        mem[flAddr] <= (mem[flAddr] & flWdata) ^ corruptMask;
        lastData  <= flWdata;
        mBusy     <= 1'b1;
        busyCnt   <= busyLen;
        progArmed <= 1'b0;
      end else if (bufSt == 2'd1) begin
        bufLeft <= int'(flWdata) + 1;
        bufSt   <= 2'd2;
      end else if (bufSt == 2'd2 && bufLeft != 0) begin
        mem[flAddr] <= mem[flAddr] & flWdata;
        lastData <= flWdata;
        bufLeft  <= bufLeft - 1;
      end else if (bufSt == 2'd2 && flWdata[7:0] == 8'h29) begin
        mBusy   <= 1'b1;
        busyCnt <= busyLen;
        bufSt   <= 2'd0;
      end else if (flWdata[7:0] == 8'hF0) begin
        ulSt <= 2'd0; stTo <= 1'b0; stAb <= 1'b0; mBusy <= 1'b0;
        progArmed <= 1'b0; eraseArmed <= 1'b0; bufSt <= 2'd0; raceHold <= 1'b0;
      end else if (ulSt == 2'd0 && flAddr == ADDR_W'('h555) && flWdata[7:0] == 8'hAA) begin
        ulSt <= 2'd1;
      end else if (ulSt == 2'd1 && flAddr == ADDR_W'('h2AA) && flWdata[7:0] == 8'h55) begin
        ulSt <= 2'd2;
      end else if (ulSt == 2'd2) begin
        ulSt <= 2'd0;
        case (flWdata[7:0])
          8'hA0: progArmed <= 1'b1;
          8'h80: eraseArmed <= 1'b1;
          8'h25: bufSt <= 2'd1;
          8'h30: if (eraseArmed) begin
            for (int i = 0; i < (1 << BLOCK_AW); i++)
              mem[{flAddr[ADDR_W-1:BLOCK_AW], BLOCK_AW'(i)}] <= '1;
            lastData   <= '1;
            mBusy      <= 1'b1;
            busyCnt    <= busyLen;
            eraseArmed <= 1'b0;
          end
          default: ;
        endcase
      end else begin
        ulSt <= 2'd0;
      end
    end
  end

  // scoreboard
  int tests = 0;
  int fails = 0;
  int doneCount = 0;
  logic [2:0] expRes [$];
  string      expTag [$];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && done) begin
      if (expRes.size() == 0) begin
        check(1'b0, "R11", "done with no expected item", 1, 0);
      end else begin
        automatic logic [2:0] e = expRes.pop_front();
        automatic string t = expTag.pop_front();
        check(result == e, t, "result code", result, e);
      end
      doneCount++;
    end
  end

  function automatic logic [ADDR_W-1:0] blockOf(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:BLOCK_AW], {BLOCK_AW{1'b0}}};
  endfunction

  task automatic expW(input int a, input int d);
    expA.push_back(ADDR_W'(a));
    expD.push_back(DATA_W'(d));
  endtask

  task automatic expPrefix();
    expW('h555, 'hAA);
    expW('h2AA, 'h55);
  endtask

  task automatic compareLog(input string tag);
    check(logA.size() == expA.size(), tag, "write count", logA.size(), expA.size());
    if (logA.size() == expA.size()) begin
      for (int i = 0; i < expA.size(); i++) begin
        check(logA[i] == expA[i] && logD[i] == expD[i], tag,
              $sformatf("write %0d addr/data", i),
              {logA[i], logD[i]}, {expA[i], expD[i]});
      end
    end
  endtask

  // drive one operation; a second start is pulsed mid-flight when asked
  task automatic runOp(input int kind, input int addr, input int data, input int cnt,
                       input int expResult, input string tag, input bit poke);
    int prev;
    logA.delete(); logD.delete();
    expRes.push_back(3'(expResult));
    expTag.push_back(tag);
    prev = doneCount;
    @(negedge clk);
    opKind = 2'(kind); opAddr = ADDR_W'(addr); opData = DATA_W'(data);
    bufCount = CNT_W'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R11", "busy after start", busy, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      opKind = 2'd1; opAddr = ADDR_W'('h7C0); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (doneCount == prev) @(negedge clk);
    @(negedge clk);
    check(busy == 1'b0, "R11", "idle after done", busy, 0);
    compareLog(tag);
    expA.delete(); expD.delete();
  endtask

  task automatic expProgram(input int a, input int d, input bit recover);
    expPrefix(); expW('h555, 'hA0); expW(a, d);
    if (recover) expPrefix();
    expW('h555, 'hF0);
  endtask

  task automatic expBuffer(input int a, input int n, input bit recover);
    int b;
    b = int'(blockOf(ADDR_W'(a)));
    expPrefix(); expW(b, 'h25); expW(b, n - 1);
    for (int i = 0; i < n; i++) expW(a + i, int'(bufMem[i]));
    expW(b, 'h29);
    if (recover) expPrefix();
    expW('h555, 'hF0);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog: run did not end");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEM_N; i++) mem[i] = '1;
    for (int i = 0; i < BUF_WORDS; i++) bufMem[i] = DATA_W'(16'h1111 * (i + 1) + 16'h0003);
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0, "R12", "busy/done in reset", {busy, done}, 0);
    check(flWe == 0 && flRe == 0, "R12", "bus strobes in reset", {flWe, flRe}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 0 && flWe == 0 && flRe == 0, "R12", "idle after reset", {busy, flWe, flRe}, 0);

    // R11: opKind 3 is not accepted
    logA.delete();
    opKind = 2'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 0 && logA.size() == 0, "R11", "kind 3 ignored", {busy, 8'(logA.size())}, 0);

    // R1 R2 R5 R8 R9: single program
    busyLen = 4; faultKind = 0;
    expProgram('h100, 'h1234, 0);
    runOp(0, 'h100, 'h1234, 1, 0, "R2", 0);
    check(mem['h100] == 16'h1234, "R9", "programmed word", mem['h100], 16'h1234);

    // R11: second start while busy has no effect on traffic
    busyLen = 10;
    expProgram('h104, 'h8008, 0);
    runOp(0, 'h104, 'h8008, 1, 0, "R11", 1);
    check(mem['h104] == 16'h8008, "R5", "slow program word", mem['h104], 16'h8008);

    // R3: erase of the block holding 0x100..0x13F
    busyLen = 20;
    expPrefix(); expW('h555, 'h80); expPrefix(); expW('h100, 'h30); expW('h555, 'hF0);
    runOp(1, 'h105, 0, 1, 0, "R3", 0);
    check(mem['h100] == 16'hFFFF && mem['h104] == 16'hFFFF, "R3", "block erased",
          {mem['h100], mem['h104]}, 32'hFFFFFFFF);

    // R4: buffered program, partial, full, single
    busyLen = 6;
    expBuffer('h205, 4, 0);
    runOp(2, 'h205, 0, 4, 0, "R4", 0);
    for (int i = 0; i < 4; i++)
      check(mem['h205 + i] == bufMem[i], "R4", "buffered word", mem['h205 + i], bufMem[i]);
    expBuffer('h240, BUF_WORDS, 0);
    runOp(2, 'h240, 0, BUF_WORDS, 0, "R4", 0);
    check(mem['h240 + BUF_WORDS - 1] == bufMem[BUF_WORDS-1], "R4", "full buffer last word",
          mem['h240 + BUF_WORDS - 1], bufMem[BUF_WORDS-1]);
    expBuffer('h285, 1, 0);
    runOp(2, 'h285, 0, 1, 0, "R4", 0);

    // R6: persistent timeout flag
    busyLen = 3; faultKind = 1;
    expProgram('h102, 'h4321, 0);
    runOp(0, 'h102, 'h4321, 1, 1, "R6", 0);

    // R6: timeout flag that clears before the re-read
    faultKind = 3;
    expProgram('h103, 'h0F0E, 0);
    runOp(0, 'h103, 'h0F0E, 1, 0, "R6", 0);

    // R7: abort during buffered program, with recovery prefix
    faultKind = 2;
    expBuffer('h300, 2, 1);
    runOp(2, 'h300, 0, 2, 2, "R7", 0);

    // R7 R10: abort flag outside buffered mode is not an abort
    expProgram('h310, 'h2468, 0);
    runOp(0, 'h310, 'h2468, 1, 4, "R7", 0);

    // R10: device never finishes within the poll budget
    faultKind = 0; busyLen = 100;
    expProgram('h320, 'h1357, 0);
    runOp(0, 'h320, 'h1357, 1, 4, "R10", 0);

    // R9: stored word differs in bit 0 only
    faultKind = 4; busyLen = 4;
    expProgram('h330, 'h5678, 0);
    runOp(0, 'h330, 'h5678, 1, 3, "R9", 0);

    repeat (4) @(negedge clk);
    check(expRes.size() == 0, "R11", "all results delivered", expRes.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule